// File: doc/BRIEF.md
# Number-Addressed Vectored Interrupt Controller

This block collects 64 interrupt sources and presents them to a processor as two request lines: a normal request and a fast request. Each source carries an enable bit, a class bit that sends it to the fast or the normal line, and a 4-bit priority. Software can also force any source active. The block reports pending status for each class separately. For the normal class it reports the number of the winning source as a vector.

Enables can be changed one at a time. Software writes a source number to a set address or to a clear address, so no read-modify-write of a shared word is needed. Enables can also be read and written as whole 32-bit words. A programmable signed threshold holds back normal requests whose priority does not exceed it. The threshold value -1 (all ones) lets every priority through. Register reads are combinational from the address. Writes take effect at the next rising clock edge.

Top module: `irq_num_ctrl`

## Requirements
- R1: After reset every enable, type, force and priority bit is 0 and the mask register reads 0. Both request outputs are low and both vector registers read 0xFFFFFFFF.
- R2: Writing a source number N (0 to 63) to address 0x08 sets only enable bit N. Writing a value of 64 or more there changes nothing.
- R3: Writing a source number N (0 to 63) to address 0x0C clears only enable bit N. All other enable bits are unchanged.
- R4: The enable word for sources 63..32 is read and written at 0x10, and the word for sources 31..0 at 0x14, with bit k of a word standing for source 32*word+k. Writing 0 to both words disables every source.
- R5: Type words sit at 0x18 (sources 63..32) and 0x1C (sources 31..0). A type bit of 1 puts the source in the fast class and 0 puts it in the normal class.
- R6: A source is pending when (raw input OR force bit) AND enable bit is 1. Raw inputs read at 0x48/0x4C, force bits read and write at 0x50/0x54, normal-class pending reads at 0x58/0x5C and fast-class pending reads at 0x60/0x64, each pair given high word first. No source is pending in both classes.
- R7: Priority register x (0..7) sits at address 0x20 + 4*(7-x) and covers sources 8x..8x+7. Source 8x+j uses bits 4j+3:4j.
- R8: The mask register at 0x04 is a signed 32-bit threshold. The normal request is high exactly when some normal-class source is pending whose priority is greater than the threshold. With all ones written, every pending normal source requests.
- R9: The fast request is high exactly when at least one fast-class source is pending.
- R10: The normal vector at 0x40 holds, in bits 31:16, the number of the pending normal source with the highest priority, with bits 15:0 zero. Ties go to the higher source number. It reads 0xFFFFFFFF when no normal source is pending.
- R11: The fast vector at 0x44 holds, in bits 31:16, the highest-numbered pending fast source, with bits 15:0 zero. It reads 0xFFFFFFFF when none is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| src_i | input | 64 | Raw interrupt source levels |
| nirq_o | output | 1 | Normal interrupt request |
| firq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default parameters: 64 sources and 4-bit priorities, which fill eight priority registers of eight fields each. At these values the tests reach both enable words, including a source in the upper word selected by number. They also reach a priority tie between a low and a high source, threshold values of 0, a positive number and -1, and a source moved from the normal class to the fast class. A source number one past the last valid number is written to the set address to show that it is ignored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned BUS_W = 32;

  // Register byte addresses
  localparam logic [6:0] A_CTRL   = 7'h00;
  localparam logic [6:0] A_MASK   = 7'h04;
  localparam logic [6:0] A_ENNUM  = 7'h08;
  localparam logic [6:0] A_DISNUM = 7'h0C;
  localparam logic [6:0] A_ENH    = 7'h10;
  localparam logic [6:0] A_ENL    = 7'h14;
  localparam logic [6:0] A_TYPH   = 7'h18;
  localparam logic [6:0] A_TYPL   = 7'h1C;
  localparam logic [6:0] A_PRIO0  = 7'h20;
  localparam logic [6:0] A_NVEC   = 7'h40;
  localparam logic [6:0] A_FVEC   = 7'h44;
  localparam logic [6:0] A_RAWH   = 7'h48;
  localparam logic [6:0] A_RAWL   = 7'h4C;
  localparam logic [6:0] A_FRCH   = 7'h50;
  localparam logic [6:0] A_FRCL   = 7'h54;
  localparam logic [6:0] A_NPH    = 7'h58;
  localparam logic [6:0] A_NPL    = 7'h5C;
  localparam logic [6:0] A_FPH    = 7'h60;
  localparam logic [6:0] A_FPL    = 7'h64;

  // Priority register index from a byte address in the 0x20..0x3C window
  function automatic logic [2:0] prio_reg_of(input logic [6:0] a);
    logic [2:0] slot;
    slot = a[4:2];
    return 3'd7 - slot;
  endfunction

  // Vector word: source number in 31:16, or all ones when nothing is pending
  function automatic logic [31:0] vec_word(input logic vld, input logic [15:0] num);
    return vld ? {num, 16'h0000} : 32'hFFFF_FFFF;
  endfunction

  // Signed threshold comparison of an unsigned priority against the mask
  function automatic logic prio_above(input logic [7:0] prio, input logic [31:0] mask);
    return $signed({24'h0, prio}) > $signed(mask);
  endfunction

endpackage

// File: rtl/irqc_prio_arb.sv
module irqc_prio_arb #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      any_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic [PRIO_W-1:0]         prio_o
);
  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    prio_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] >= prio_o)) begin
        any_o  = 1'b1;
        idx_o  = IDX_W'(i);
        prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irqc_fast_enc.sv
module irqc_fast_enc #(
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_num_ctrl.sv
module irq_num_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [6:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [63:0] src_i,
  output logic        nirq_o,
  output logic        firq_o
);
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);
  localparam int unsigned WORDS   = NUM_SRC / BUS_W;
  localparam int unsigned PER_REG = BUS_W / PRIO_W;
  localparam int unsigned NPRIO   = NUM_SRC / PER_REG;

  logic [NUM_SRC-1:0]        en_q, type_q, force_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic [31:0]               mask_q;

  // Named internal events, visible to the checker
  logic                      wr_en_num, wr_dis_num, num_ok;
  logic [IDX_W-1:0]          num_idx;
  logic [NUM_SRC-1:0]        active, npend, fpend;
  logic                      n_any, f_any;
  logic [IDX_W-1:0]          n_idx, f_idx;
  logic [PRIO_W-1:0]         n_prio;
  logic                      prio_win;

  assign num_ok     = bus_wdata < NUM_SRC;
  assign num_idx    = bus_wdata[IDX_W-1:0];
  assign wr_en_num  = bus_wr && bus_addr == A_ENNUM  && num_ok;
  assign wr_dis_num = bus_wr && bus_addr == A_DISNUM && num_ok;

  assign active = (src_i | force_q) & en_q;
  assign npend  = active & ~type_q;
  assign fpend  = active & type_q;

  irqc_prio_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .pend_i (npend),
    .prio_i (prio_q),
    .any_o  (n_any),
    .idx_o  (n_idx),
    .prio_o (n_prio)
  );

  irqc_fast_enc #(.NUM_SRC(NUM_SRC)) u_fenc (
    .pend_i (fpend),
    .any_o  (f_any),
    .idx_o  (f_idx)
  );

  assign prio_win = prio_above(8'(n_prio), mask_q);
  assign nirq_o   = n_any && prio_win;
  assign firq_o   = f_any;

  // Register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      type_q  <= '0;
      force_q <= '0;
      prio_q  <= '0;
      mask_q  <= '0;
    end else begin
      if (wr_en_num)  en_q[num_idx] <= 1'b1;
      if (wr_dis_num) en_q[num_idx] <= 1'b0;
      if (bus_wr) begin
        if (bus_addr == A_MASK) mask_q <= bus_wdata;
        for (int w = 0; w < WORDS; w++) begin
          // word 0 is the low word, the high word sits at the lower address
          if (bus_addr == (A_ENL  - 7'(4*w))) en_q   [w*BUS_W +: BUS_W] <= bus_wdata;
          if (bus_addr == (A_TYPL - 7'(4*w))) type_q [w*BUS_W +: BUS_W] <= bus_wdata;
          if (bus_addr == (A_FRCL - 7'(4*w))) force_q[w*BUS_W +: BUS_W] <= bus_wdata;
        end
        for (int r = 0; r < NPRIO; r++) begin
          if (bus_addr[6:5] == A_PRIO0[6:5] && bus_addr[1:0] == 2'b00 &&
              prio_reg_of(bus_addr) == 3'(r))
            prio_q[r*BUS_W +: BUS_W] <= bus_wdata;
        end
      end
    end
  end

  // Register reads
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = '0;
      A_MASK:  bus_rdata = mask_q;
      A_ENH:   bus_rdata = en_q[63:32];
      A_ENL:   bus_rdata = en_q[31:0];
      A_TYPH:  bus_rdata = type_q[63:32];
      A_TYPL:  bus_rdata = type_q[31:0];
      A_NVEC:  bus_rdata = vec_word(n_any, 16'(n_idx));
      A_FVEC:  bus_rdata = vec_word(f_any, 16'(f_idx));
      A_RAWH:  bus_rdata = src_i[63:32];
      A_RAWL:  bus_rdata = src_i[31:0];
      A_FRCH:  bus_rdata = force_q[63:32];
      A_FRCL:  bus_rdata = force_q[31:0];
      A_NPH:   bus_rdata = npend[63:32];
      A_NPL:   bus_rdata = npend[31:0];
      A_FPH:   bus_rdata = fpend[63:32];
      A_FPL:   bus_rdata = fpend[31:0];
      default: begin
        if (bus_addr[6:5] == A_PRIO0[6:5] && bus_addr[1:0] == 2'b00)
          bus_rdata = prio_q[32*prio_reg_of(bus_addr) +: 32];
      end
    endcase
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned NUM_SRC = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en_num,
  input logic               wr_dis_num,
  input logic [5:0]         num_idx,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] npend,
  input logic [NUM_SRC-1:0] fpend,
  input logic               n_any,
  input logic [31:0]        mask_q,
  input logic               nirq_o,
  input logic               firq_o
);
  // R2: a number written to the set address turns that enable on
  a_r2_num_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_num |=> en_q[$past(num_idx)]);

  // R3: a number written to the clear address turns that enable off
  a_r3_num_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis_num |=> !en_q[$past(num_idx)]);

  // R6: the two classes never share a pending source
  a_r6_class_split: assert property (@(posedge clk) disable iff (!rst_n)
    (npend & fpend) == '0);

  // R8: no normal request without a normal pending source
  a_r8_quiet_normal: assert property (@(posedge clk) disable iff (!rst_n)
    !n_any |-> !nirq_o);

  // R8: an all-ones mask lets any pending normal source through
  a_r8_open_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (n_any && mask_q == 32'hFFFF_FFFF) |-> nirq_o);

  // R9: fast request tracks fast pending
  a_r9_fast_req: assert property (@(posedge clk) disable iff (!rst_n)
    firq_o == (fpend != '0));
endmodule

bind irq_num_ctrl irqc_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en_num  (wr_en_num),
  .wr_dis_num (wr_dis_num),
  .num_idx    (num_idx),
  .en_q       (en_q),
  .npend      (npend),
  .fpend      (fpend),
  .n_any      (n_any),
  .mask_q     (mask_q),
  .nirq_o     (nirq_o),
  .firq_o     (firq_o)
);

// File: tb/irq_num_ctrl_tb.sv
module irq_num_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_i = '0;
  logic        nirq_o, firq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_num_ctrl dut_i (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .src_i (src_i),
    .nirq_o (nirq_o), .firq_o (firq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset();
    rd_chk("R1 enh", 7'h10, 0);
    rd_chk("R1 enl", 7'h14, 0);
    rd_chk("R1 mask", 7'h04, 0);
    rd_chk("R1 prio0", 7'h3C, 0);
    rd_chk("R1 nvec", 7'h40, 32'hFFFF_FFFF);
    rd_chk("R1 fvec", 7'h44, 32'hFFFF_FFFF);
    chk("R1 nirq", 32'(nirq_o), 0);
    chk("R1 firq", 32'(firq_o), 0);
  endtask

  task automatic t_num_set_clear();
    wr(7'h08, 5);
    wr(7'h08, 40);
    rd_chk("R2 enl", 7'h14, 32'h0000_0020);
    rd_chk("R2 enh", 7'h10, 32'h0000_0100);
    wr(7'h08, 64);
    rd_chk("R2 out of range enl", 7'h14, 32'h0000_0020);
    rd_chk("R2 out of range enh", 7'h10, 32'h0000_0100);
    wr(7'h14, 32'hFFFF_FFFF);
    wr(7'h0C, 3);
    rd_chk("R3 enl", 7'h14, 32'hFFFF_FFF7);
    rd_chk("R3 enh", 7'h10, 32'h0000_0100);
  endtask

  task automatic t_words();
    wr(7'h10, 32'hA5A5_0000);
    rd_chk("R4 enh rw", 7'h10, 32'hA5A5_0000);
    wr(7'h10, 0);
    wr(7'h14, 0);
    rd_chk("R4 enh zero", 7'h10, 0);
    rd_chk("R4 enl zero", 7'h14, 0);
  endtask

  task automatic t_pending();
    src_i = (64'd1 << 7) | (64'd1 << 45);
    wr(7'h08, 7);
    wr(7'h50, 32'h0004_0000);  // force source 50
    wr(7'h08, 50);
    rd_chk("R6 raw high", 7'h48, 32'h0000_2000);
    rd_chk("R6 raw low", 7'h4C, 32'h0000_0080);
    rd_chk("R6 force high", 7'h50, 32'h0004_0000);
    rd_chk("R6 npend high", 7'h58, 32'h0004_0000);
    rd_chk("R6 npend low", 7'h5C, 32'h0000_0080);
    rd_chk("R6 fpend low", 7'h64, 0);
  endtask

  task automatic t_priority_mask();
    chk("R8 prio 0 vs mask 0", 32'(nirq_o), 0);
    wr(7'h3C, 32'h3000_0000);  // source 7 -> priority 3
    rd_chk("R7 prio reg 0", 7'h3C, 32'h3000_0000);
    chk("R8 prio 3 vs mask 0", 32'(nirq_o), 1);
    rd_chk("R10 highest", 7'h40, 32'h0007_0000);
    wr(7'h04, 5);
    chk("R8 mask 5", 32'(nirq_o), 0);
    wr(7'h3C, 0);
    wr(7'h04, 32'hFFFF_FFFF);
    chk("R8 open mask prio 0", 32'(nirq_o), 1);
    wr(7'h3C, 32'h3000_0000);
    wr(7'h24, 32'h0000_0300);  // source 50 -> priority 3
    rd_chk("R10 tie higher num", 7'h40, 32'h0032_0000);
  endtask

  task automatic t_fast();
    chk("R9 no fast", 32'(firq_o), 0);
    wr(7'h18, 32'h0004_0000);  // source 50 fast
    chk("R9 fast req", 32'(firq_o), 1);
    rd_chk("R5 fpend high", 7'h60, 32'h0004_0000);
    rd_chk("R5 npend high", 7'h58, 0);
    rd_chk("R11 fvec", 7'h44, 32'h0032_0000);
    rd_chk("R10 after move", 7'h40, 32'h0007_0000);
    wr(7'h10, 0);
    wr(7'h14, 0);
    chk("R4 off nirq", 32'(nirq_o), 0);
    chk("R4 off firq", 32'(firq_o), 0);
    rd_chk("R10 none", 7'h40, 32'hFFFF_FFFF);
    rd_chk("R11 none", 7'h44, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_num_set_clear();
    t_words();
    t_pending();
    t_priority_mask();
    t_fast();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule